// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose pin port of up to sixteen pins. The pin count is set by a parameter. Each pin has a stored output value, a direction bit that enables its output driver, and an input path that passes through a two-flop synchroniser. Software reaches all of this through a simple word-addressed 32-bit register bus with a select, a write strobe and a combinational read path.

Every pin also has its own event detector. The detector can be set to catch a rising edge, a falling edge, either edge, a high level or a low level. When the pin's enable bit is set, a detected event latches into a sticky status bit. Software clears status bits by writing ones to a clear register. Two more write-one registers set and remove a per-pin mask. The masked, enabled status vector is readable and is ORed into a single interrupt line.

A soft-reset register holds all port state at zero for as long as its bit is 1. Writing 1 and then 0 to it returns the port to its power-on state.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at word addresses (bus_addr) 0 enable, 1 status (read-only), 2 display (read-only), 3 clear (reads 0), 4 mask-set (reads the mask), 5 mask-clear (reads 0), 6 output, 7 input (read-only), 8 direction, 9 mode-low, 10 mode-high, 11 reserved (reads 0, writes ignored), 12 soft reset (bit 0). Per-pin vectors use bit n for pin n.
- R2: After reset every register reads zero, pin_oe is all zero and irq is 0.
- R3: pin_oe follows the direction register (1 = output) and pin_out follows the output register. Bits at or above the pin count are ignored on write and read as zero in every register.
- R4: The input register returns pin_in after a two-flop synchroniser, so a change is readable by the third clock edge.
- R5: Each pin has a 3-bit mode field. Pins 0–7 use mode-low bits [4n+2:4n] and pins 8–15 use mode-high bits [4(n−8)+2:4(n−8)]. The encodings are 0 falling, 1 rising, 2 low level, 3 high level and 4 both edges. The fourth bit of each slot, and the slots of unimplemented pins, read zero.
- R6: In edge modes a status bit latches only on the selected transition(s) of the synchronised input.
- R7: In level modes the status bit latches while the level holds, and it reappears on the cycle after a clear if the level still holds.
- R8: A status bit latches only while its enable bit is 1. Clearing the enable bit keeps an already latched status bit.
- R9: Writing 1 to a clear bit clears that status bit and 0 bits have no effect. A new event in the same cycle as the clear wins.
- R10: Writing 1 to a mask-set bit sets the mask and writing 1 to a mask-clear bit removes it. 0 bits have no effect in either register.
- R11: Display reads status AND enable AND NOT mask, and irq is 1 exactly when that vector is nonzero.
- R12: While the soft-reset bit is 1, all other port state is held at zero and writes to it are ignored. Writing 0 releases the port.
- R13: Mode codes 5, 6 and 7 detect nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output values to the pads |
| pin_oe | output | NPINS | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with twelve pins rather than the default sixteen. This makes the ignored upper bits reachable: all-ones writes must read back with bits 12–15 clear, and the mode-high register must keep only four populated slots. With twelve pins, mode-high still holds real pins, so both halves of the mode-field layout are exercised. Those pins and the low pins together cover every trigger code, the unused codes, and clear or mask writes that leave neighbouring bits untouched.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the pin port.
// Assumes a 4-bit word address and at most 16 pins per port.
package gpio_port_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int MODE_W   = 3;
    localparam int SLOT_W   = 4;
    localparam int BANK_PINS = 8;
    localparam int MAX_PINS = 16;

    typedef enum logic [MODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_DISPLAY = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_MSET    = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_MCLR    = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_OUT     = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_IN      = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_MODE_LO = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_MODE_HI = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_SRST    = 4'd12;
endpackage

// File: rtl/gpio_sync_bank.sv
// Multi-stage synchroniser for a vector of asynchronous pin levels.
// Assumes STAGES >= 1; every bit is synchronised independently.
module gpio_sync_bank #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the sampled pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
// Event detector and sticky status bit for one pin.
// Assumes lvl is already synchronised to clk. When a clear and a new
// event occur in the same cycle, the event wins.
module gpio_pin_detect
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    input  logic              enable,
    input  logic              clr,
    output logic              status
);
    logic prev_q;
    logic rise, fall, hit;

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // Decode the trigger mode into a single event strobe.
    always_comb begin
        case (mode)
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            TRIG_LOW:  hit = ~lvl;
            TRIG_HIGH: hit = lvl;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // Sticky status: cleared on request, set by an enabled event.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 1'b0;
        else        status <= (status & ~clr) | (enable & hit);
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Register file for the pin port: write decode, storage and read mux.
// Assumes NPINS <= 16. The soft-reset bit is cleared only by rst_n;
// all other state is also cleared while that bit is set.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    input  logic [NPINS-1:0]             status_vec,
    input  logic [NPINS-1:0]             display_vec,
    input  logic [NPINS-1:0]             pin_lvl,
    output logic [NPINS-1:0]             en_q,
    output logic [NPINS-1:0]             mask_q,
    output logic [NPINS-1:0]             out_q,
    output logic [NPINS-1:0]             dir_q,
    output logic [NPINS-1:0][MODE_W-1:0] mode_q,
    output logic [NPINS-1:0]             clr_pulse,
    output logic                         srst_q,
    output logic                         port_rst_n
);
    logic               wr_go;
    logic [NPINS-1:0]   wd;
    logic [WORD_W-1:0]  mode_lo_rd, mode_hi_rd;
    logic               unused_wdata;

    assign wr_go        = bus_sel & bus_wr;
    assign wd           = bus_wdata[NPINS-1:0];
    assign unused_wdata = ^bus_wdata;

    // Soft-reset bit, cleared only by the hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              srst_q <= 1'b0;
        else if (wr_go && bus_addr == OFS_SRST)  srst_q <= bus_wdata[0];
    end

    assign port_rst_n = rst_n & ~srst_q;

    // Interrupt enable vector.
    always_ff @(posedge clk) begin
        if (!port_rst_n)                           en_q <= '0;
        else if (wr_go && bus_addr == OFS_ENABLE)  en_q <= wd;
    end

    // Mask vector with separate write-one set and write-one clear.
    always_ff @(posedge clk) begin
        if (!port_rst_n)                           mask_q <= '0;
        else if (wr_go && bus_addr == OFS_MSET)    mask_q <= mask_q | wd;
        else if (wr_go && bus_addr == OFS_MCLR)    mask_q <= mask_q & ~wd;
    end

    // Output values and direction bits.
    always_ff @(posedge clk) begin
        if (!port_rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_go) begin
            if (bus_addr == OFS_OUT) out_q <= wd;
            if (bus_addr == OFS_DIR) dir_q <= wd;
        end
    end

    // Per-pin mode fields, two banks of eight 4-bit slots.
    always_ff @(posedge clk) begin
        if (!port_rst_n) begin
            mode_q <= '0;
        end else if (wr_go) begin
            for (int p = 0; p < NPINS; p++) begin
                if (p < BANK_PINS && bus_addr == OFS_MODE_LO)
                    mode_q[p] <= bus_wdata[(p % BANK_PINS)*SLOT_W +: MODE_W];
                if (p >= BANK_PINS && bus_addr == OFS_MODE_HI)
                    mode_q[p] <= bus_wdata[(p % BANK_PINS)*SLOT_W +: MODE_W];
            end
        end
    end

    // One-cycle clear strobe to the status bits.
    assign clr_pulse = (wr_go && bus_addr == OFS_CLEAR) ? wd : '0;

    // Pack the mode fields back into their read words.
    always_comb begin
        mode_lo_rd = '0;
        mode_hi_rd = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < BANK_PINS)
                mode_lo_rd[(p % BANK_PINS)*SLOT_W +: MODE_W] = mode_q[p];
            else
                mode_hi_rd[(p % BANK_PINS)*SLOT_W +: MODE_W] = mode_q[p];
        end
    end

    // Read mux; unselected or undefined addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_ENABLE:  bus_rdata = WORD_W'(en_q);
                OFS_STATUS:  bus_rdata = WORD_W'(status_vec);
                OFS_DISPLAY: bus_rdata = WORD_W'(display_vec);
                OFS_MSET:    bus_rdata = WORD_W'(mask_q);
                OFS_OUT:     bus_rdata = WORD_W'(out_q);
                OFS_IN:      bus_rdata = WORD_W'(pin_lvl);
                OFS_DIR:     bus_rdata = WORD_W'(dir_q);
                OFS_MODE_LO: bus_rdata = mode_lo_rd;
                OFS_MODE_HI: bus_rdata = mode_hi_rd;
                OFS_SRST:    bus_rdata = WORD_W'(srst_q);
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
// Top of the pin port: synchroniser, register file, per-pin detectors
// and the combined interrupt. Assumes 1 <= NPINS <= 16 and a pad ring
// that applies pin_oe/pin_out itself.
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    logic                         port_rst_n;
    logic                         srst_q;
    logic [NPINS-1:0]             pin_lvl;
    logic [NPINS-1:0]             en_q, mask_q, out_q, dir_q;
    logic [NPINS-1:0][MODE_W-1:0] mode_q;
    logic [NPINS-1:0]             clr_pulse;
    logic [NPINS-1:0]             status_q;
    logic [NPINS-1:0]             display_vec;

    gpio_sync_bank #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (port_rst_n),
        .d     (pin_in),
        .q     (pin_lvl)
    );

    gpio_port_regs #(.NPINS(NPINS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .status_vec  (status_q),
        .display_vec (display_vec),
        .pin_lvl     (pin_lvl),
        .en_q        (en_q),
        .mask_q      (mask_q),
        .out_q       (out_q),
        .dir_q       (dir_q),
        .mode_q      (mode_q),
        .clr_pulse   (clr_pulse),
        .srst_q      (srst_q),
        .port_rst_n  (port_rst_n)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_detect u_det (
            .clk    (clk),
            .rst_n  (port_rst_n),
            .lvl    (pin_lvl[p]),
            .mode   (mode_q[p]),
            .enable (en_q[p]),
            .clr    (clr_pulse[p]),
            .status (status_q[p])
        );
    end

    // Masked, enabled status and the combined request line.
    assign display_vec = status_q & en_q & ~mask_q;
    assign irq         = |display_vec;

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Property checker for gpio_irq_port, attached with bind.
// Assumes it observes the top's bus ports and internal state vectors.
module gpio_irq_port_chk #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq,
    input logic             srst_q,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] status_q
);
    logic [NPINS-1:0] wd;
    logic             unused_chk;
    logic             wr_mset, wr_mclr, wr_clr;

    assign wd         = bus_wdata[NPINS-1:0];
    assign unused_chk = ^bus_wdata;
    assign wr_mset    = bus_sel && bus_wr && bus_addr == 4'd4;
    assign wr_mclr    = bus_sel && bus_wr && bus_addr == 4'd5;
    assign wr_clr     = bus_sel && bus_wr && bus_addr == 4'd3;

    AST_SRST_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (en_q == '0 && mask_q == '0 && dir_q == '0 && status_q == '0)); // R12
    AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0)); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && !srst_q) |=> ((~status_q & $past(status_q)) == '0)); // R9
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mset && !srst_q) |=> ((mask_q & $past(wd)) == $past(wd))); // R10
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mclr && !srst_q) |=> ((mask_q & $past(wd)) == '0)); // R10
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0 && en_q != '0)); // R11
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .srst_q    (srst_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .dir_q     (dir_q),
    .status_q  (status_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic port_clean();
        pin_in = '0;
        settle();
        wr(4'd12, 32'd1);
        wr(4'd12, 32'd0);
        settle();
    endtask

    task automatic t_reset();
        for (int a = 0; a < 13; a++) rd_chk("R2 reset reg", 4'(a), 32'd0);
        check("R2 pin_oe", 32'(pin_oe), 32'd0);
        check("R2 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_direction();
        wr(4'd8, 32'hFFFF_FFFF);
        rd_chk("R3 dir upper bits", 4'd8, 32'h0000_0FFF);
        check("R3 pin_oe", 32'(pin_oe), 32'h0FFF);
        wr(4'd6, 32'hFFFF_FA5A);
        rd_chk("R3 out upper bits", 4'd6, 32'h0000_0A5A);
        check("R3 pin_out", 32'(pin_out), 32'h0A5A);
        wr(4'd11, 32'hFFFF_FFFF);
        rd_chk("R1 reserved reads 0", 4'd11, 32'd0);
        port_clean();
    endtask

    task automatic t_input();
        pin_in = 12'h9C3;
        settle();
        rd_chk("R4 input", 4'd7, 32'h9C3);
        pin_in = 12'h03C;
        settle();
        rd_chk("R4 input second", 4'd7, 32'h03C);
        port_clean();
    endtask

    task automatic t_mode_fields();
        wr(4'd9, 32'hFFFF_FFFF);
        rd_chk("R5 mode-low slots", 4'd9, 32'h7777_7777);
        wr(4'd10, 32'hFFFF_FFFF);
        rd_chk("R5 mode-high slots", 4'd10, 32'h0000_7777);
        port_clean();
    endtask

    task automatic t_rise();
        wr(4'd9, 32'h1);
        wr(4'd0, 32'h1);
        settle();
        rd_chk("R6 rise idle", 4'd1, 32'd0);
        pin_in[0] = 1'b1;
        settle();
        rd_chk("R6 rise status", 4'd1, 32'h1);
        rd_chk("R11 rise display", 4'd2, 32'h1);
        check("R11 rise irq", 32'(irq), 32'd1);
        wr(4'd3, 32'h1);
        rd_chk("R1 clear reads 0", 4'd3, 32'd0);
        pin_in[0] = 1'b0;
        settle();
        rd_chk("R6 rise ignores fall", 4'd1, 32'd0);
        check("R11 irq drops", 32'(irq), 32'd0);
        port_clean();
    endtask

    task automatic t_fall();
        pin_in[1] = 1'b1;
        settle();
        wr(4'd0, 32'h2);
        settle();
        rd_chk("R6 fall ignores high", 4'd1, 32'd0);
        pin_in[1] = 1'b0;
        settle();
        rd_chk("R6 fall status", 4'd1, 32'h2);
        port_clean();
    endtask

    task automatic t_both();
        wr(4'd10, 32'h40);
        wr(4'd0, 32'h200);
        settle();
        pin_in[9] = 1'b1;
        settle();
        rd_chk("R6 both rise", 4'd1, 32'h200);
        wr(4'd3, 32'h200);
        settle();
        rd_chk("R6 both cleared", 4'd1, 32'd0);
        pin_in[9] = 1'b0;
        settle();
        rd_chk("R6 both fall", 4'd1, 32'h200);
        port_clean();
    endtask

    task automatic t_level();
        wr(4'd9, 32'h0000_2300);
        pin_in[3] = 1'b1;
        settle();
        wr(4'd0, 32'hC);
        settle();
        rd_chk("R7 level idle", 4'd1, 32'd0);
        pin_in[2] = 1'b1;
        settle();
        rd_chk("R7 high level", 4'd1, 32'h4);
        wr(4'd3, 32'h4);
        rd_chk("R7 re-asserts", 4'd1, 32'h4);
        pin_in[2] = 1'b0;
        settle();
        wr(4'd3, 32'h4);
        rd_chk("R7 high gone", 4'd1, 32'd0);
        pin_in[3] = 1'b0;
        settle();
        rd_chk("R7 low level", 4'd1, 32'h8);
        port_clean();
    endtask

    task automatic t_enable_gate();
        wr(4'd9, 32'h0001_0000);
        pin_in[4] = 1'b1;
        settle();
        rd_chk("R8 disabled no latch", 4'd1, 32'd0);
        pin_in[4] = 1'b0;
        settle();
        wr(4'd0, 32'h10);
        pin_in[4] = 1'b1;
        settle();
        rd_chk("R8 enabled latch", 4'd1, 32'h10);
        wr(4'd0, 32'h0);
        rd_chk("R8 status kept", 4'd1, 32'h10);
        rd_chk("R11 display gated", 4'd2, 32'd0);
        check("R11 irq gated", 32'(irq), 32'd0);
        port_clean();
    endtask

    task automatic t_clear();
        wr(4'd9, 32'h0010_0001);
        wr(4'd0, 32'h21);
        settle();
        pin_in[0] = 1'b1; pin_in[5] = 1'b1;
        settle();
        rd_chk("R9 both latched", 4'd1, 32'h21);
        wr(4'd3, 32'h1);
        rd_chk("R9 partial clear", 4'd1, 32'h20);
        wr(4'd3, 32'h20);
        rd_chk("R9 full clear", 4'd1, 32'd0);
        port_clean();
    endtask

    task automatic t_mask();
        wr(4'd9, 32'h11);
        wr(4'd0, 32'h3);
        settle();
        pin_in[1:0] = 2'b11;
        settle();
        check("R11 irq unmasked", 32'(irq), 32'd1);
        wr(4'd4, 32'h1);
        rd_chk("R10 mask set", 4'd4, 32'h1);
        rd_chk("R11 display part", 4'd2, 32'h2);
        wr(4'd4, 32'h2);
        rd_chk("R10 mask both", 4'd4, 32'h3);
        rd_chk("R11 display none", 4'd2, 32'd0);
        check("R11 irq masked", 32'(irq), 32'd0);
        rd_chk("R11 status kept", 4'd1, 32'h3);
        wr(4'd5, 32'h1);
        rd_chk("R10 mask clear", 4'd4, 32'h2);
        rd_chk("R1 mask-clear reads 0", 4'd5, 32'd0);
        check("R11 irq back", 32'(irq), 32'd1);
        wr(4'd5, 32'h0);
        rd_chk("R10 zero no effect", 4'd4, 32'h2);
        port_clean();
    endtask

    task automatic t_srst();
        wr(4'd0, 32'hF);
        wr(4'd8, 32'h5);
        wr(4'd9, 32'h3);
        wr(4'd12, 32'd1);
        rd_chk("R12 srst set", 4'd12, 32'd1);
        rd_chk("R12 enable held", 4'd0, 32'd0);
        rd_chk("R12 mode held", 4'd9, 32'd0);
        check("R12 pin_oe held", 32'(pin_oe), 32'd0);
        wr(4'd0, 32'hF);
        rd_chk("R12 write ignored", 4'd0, 32'd0);
        wr(4'd12, 32'd0);
        rd_chk("R12 srst released", 4'd12, 32'd0);
        rd_chk("R12 enable after", 4'd0, 32'd0);
        wr(4'd8, 32'h5);
        check("R12 writes resume", 32'(pin_oe), 32'h5);
        port_clean();
    endtask

    task automatic t_bad_code();
        wr(4'd9, 32'h5);
        rd_chk("R13 code readback", 4'd9, 32'h5);
        wr(4'd0, 32'h1);
        pin_in[0] = 1'b1;
        settle();
        pin_in[0] = 1'b0;
        settle();
        rd_chk("R13 code 5 silent", 4'd1, 32'd0);
        wr(4'd9, 32'h7);
        pin_in[0] = 1'b1;
        settle();
        rd_chk("R13 code 7 silent", 4'd1, 32'd0);
        port_clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_input();
        t_mode_fields();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_enable_gate();
        t_clear();
        t_mask();
        t_srst();
        t_bad_code();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule